// File: doc/BRIEF.md
# Serial EEPROM Slave with Sector Write Protection

This block acts as the device side of a serial EEPROM with the common 25-series command set. It runs entirely on the system clock. Chip select, serial clock, serial data in and the hold line pass through two-flop synchronizers. Rising edges of the serial clock are found by comparing the synchronized level with its value one cycle earlier. Each transaction starts with an 8-bit command. Array commands are followed by a 16-bit address. After that, data bytes are shifted in or out most-significant bit first.

The byte array sits inside the block and has one write port and one combinational read port. Its size is set by `ADDR_W`. A small status register holds a write-enable latch and a two-bit protection level. Array writes are accepted only when the latch is set and the target address lies outside the protected region. Writes advance the address within a page of `2**PAGE_W` bytes and wrap inside that page. Reads advance across the whole array and wrap at the top. Serial clock high and low phases must each last at least four system clocks.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset `spi_miso` is 0, the status byte reads 0x00, and the block is waiting for a command byte.
- R2: A data bit is taken on each serial clock rise while chip select is low. Every field is shifted most-significant bit first. During a read, `spi_miso` presents the next bit on the third system clock edge after the rise reaches the pins, and it holds its value at all other times.
- R3: A high chip select abandons the current command at once, clearing the bit count and the partly received command. A write byte left incomplete is not stored.
- R4: While the synchronized hold line is low, clock rises and chip-select changes are both ignored. The transaction continues from where it stopped once hold returns high.
- R5: Command 0x03 reads the array. The 16-bit address that follows is truncated to its low `ADDR_W` bits.
- R6: During an array read, each completed byte increments the address modulo the array size and loads the next byte.
- R7: Command 0x06 sets the write-enable latch and command 0x04 clears it. Command 0x05 returns the status byte {4'b0, prot[1], prot[0], wel, 1'b0}, and the byte repeats while clocking continues.
- R8: Command 0x01 loads the protection level from bits 3:2 of the next byte and leaves the latch unchanged.
- R9: Command 0x02 stores a byte only if the write-enable latch is set.
- R10: Protection level 01 blocks the top quarter of the array, 10 blocks the upper half, 11 blocks every address, and 00 blocks none.
- R11: After each stored byte, only the low `PAGE_W` address bits increment, so a burst wraps to the start of its page.
- R12: Any other command value leaves the block parked until chip select rises. In that state `spi_miso` and the status register do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data into the block |
| spi_holdn | input | 1 | Hold, active low, pauses processing |
| spi_miso | output | 1 | Serial data out of the block |

## Verification
A wrong phase, bit count or address register shows up as a wrong `spi_miso` bit during the next read of status or array data. For a command-decode fault this is within eight serial clocks; for a store that was wrongly accepted or wrongly blocked, it appears at the later read-back. The bench keeps a behavioural model of the command protocol and compares `spi_miso` on every system clock, so a bit that arrives one cycle early or late is reported in that same cycle. Protection, page wrap and hold faults appear when the affected bytes are read back.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
   localparam logic [7:0] CMD_WRSTAT = 8'h01;
   localparam logic [7:0] CMD_WRITE  = 8'h02;
   localparam logic [7:0] CMD_READ   = 8'h03;
   localparam logic [7:0] CMD_WRDIS  = 8'h04;
   localparam logic [7:0] CMD_RDSTAT = 8'h05;
   localparam logic [7:0] CMD_WREN   = 8'h06;

   typedef enum logic [2:0] {
      PH_CMD  = 3'd0,
      PH_ADDR = 3'd1,
      PH_WDAT = 3'd2,
      PH_RDAT = 3'd3,
      PH_PARK = 3'd4
   } phase_e;

   function automatic logic [7:0] stat_byte(input logic wel, input logic [1:0] prot);
      return {4'b0000, prot, wel, 1'b0};
   endfunction
endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync #(
   parameter int          N       = 4,
   parameter logic [N-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      logic meta, stab;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            meta <= RST_VAL[i];
            stab <= RST_VAL[i];
         end else begin
            meta <= d[i];
            stab <= meta;
         end
      end
      assign q[i] = stab;
   end
endmodule

// File: rtl/spi_ee_status.sv
module spi_ee_status (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       set_wel,
   input  logic       clr_wel,
   input  logic       ld_prot,
   input  logic [1:0] prot_in,
   output logic       wel,
   output logic [1:0] prot
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel  <= 1'b0;
         prot <= 2'b00;
      end else begin
         if (set_wel)      wel <= 1'b1;
         else if (clr_wel) wel <= 1'b0;
         if (ld_prot)      prot <= prot_in;
      end
   end
endmodule

// File: rtl/spi_ee_mem.sv
module spi_ee_mem #(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [7:0]        wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [7:0]        rdata
);
   localparam int DEPTH = 1 << ADDR_W;
   logic [7:0] arr [DEPTH];

   always_ff @(posedge clk) begin
      if (we) arr[waddr] <= wdata;
   end
   assign rdata = arr[raddr];
endmodule

// File: rtl/spi_ee_ctrl.sv
module spi_ee_ctrl
   import spi_ee_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int PAGE_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_s,
   input  logic              hold_s,
   input  logic              mosi_s,
   input  logic              sck_rise,
   input  logic              wel,
   input  logic [1:0]        prot,
   output logic              set_wel,
   output logic              clr_wel,
   output logic              ld_prot,
   output logic [1:0]        prot_new,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_waddr,
   output logic [ADDR_W-1:0] mem_raddr,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata,
   output logic              miso
);
   localparam int HI_W = ADDR_W - PAGE_W;

   phase_e            phase;
   logic [3:0]        bitcnt;
   logic [7:0]        cmd;
   logic [15:0]       ash;
   logic [7:0]        dat;
   logic [ADDR_W-1:0] addr;
   logic              miso_q;

   logic              step, quit, last8, last16, blocked;
   logic [7:0]        cmd_nx, dat_nx;
   logic [15:0]       ash_nx;
   logic [ADDR_W-1:0] addr_pg;

   assign quit   = hold_s & cs_s;
   assign step   = hold_s & ~cs_s & sck_rise;
   assign last8  = (bitcnt == 4'd7);
   assign last16 = (bitcnt == 4'd15);
   assign cmd_nx = {cmd[6:0], mosi_s};
   assign dat_nx = {dat[6:0], mosi_s};
   assign ash_nx = {ash[14:0], mosi_s};
   assign addr_pg = {addr[ADDR_W-1:PAGE_W], PAGE_W'(addr[PAGE_W-1:0] + 1'b1)};

   always_comb begin
      unique case (prot)
         2'b00: blocked = 1'b0;
         2'b01: blocked = &addr[ADDR_W-1:ADDR_W-2];
         2'b10: blocked = addr[ADDR_W-1];
         default: blocked = 1'b1;
      endcase
   end

   assign set_wel   = step & (phase == PH_CMD) & last8 & (cmd_nx == CMD_WREN);
   assign clr_wel   = step & (phase == PH_CMD) & last8 & (cmd_nx == CMD_WRDIS);
   assign ld_prot   = step & (phase == PH_WDAT) & last8 & cmd[0];
   assign prot_new  = dat_nx[3:2];
   assign mem_we    = step & (phase == PH_WDAT) & last8 & ~cmd[0] & wel & ~blocked;
   assign mem_waddr = addr;
   assign mem_wdata = dat_nx;
   assign mem_raddr = (phase == PH_ADDR) ? ash_nx[ADDR_W-1:0] : addr + 1'b1;
   assign miso      = miso_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_CMD;
         bitcnt <= '0;
         cmd    <= '0;
         ash    <= '0;
         dat    <= '0;
         addr   <= '0;
         miso_q <= 1'b0;
      end else if (quit) begin
         phase  <= PH_CMD;
         bitcnt <= '0;
         cmd    <= '0;
      end else if (step) begin
         unique case (phase)
            PH_CMD: begin
               cmd    <= cmd_nx;
               bitcnt <= bitcnt + 1'b1;
               if (last8) begin
                  bitcnt <= '0;
                  unique case (cmd_nx)
                     CMD_WRSTAT: begin dat <= '0; phase <= PH_WDAT; end
                     CMD_WRITE, CMD_READ: begin ash <= '0; phase <= PH_ADDR; end
                     CMD_RDSTAT: begin dat <= stat_byte(wel, prot); phase <= PH_RDAT; end
                     default: phase <= PH_PARK;
                  endcase
               end
            end
            PH_ADDR: begin
               ash    <= ash_nx;
               bitcnt <= bitcnt + 1'b1;
               if (last16) begin
                  bitcnt <= '0;
                  addr   <= ash_nx[ADDR_W-1:0];
                  if (cmd[0]) begin
                     dat   <= mem_rdata;
                     phase <= PH_RDAT;
                  end else begin
                     dat   <= '0;
                     phase <= PH_WDAT;
                  end
               end
            end
            PH_WDAT: begin
               dat    <= dat_nx;
               bitcnt <= bitcnt + 1'b1;
               if (last8) begin
                  bitcnt <= '0;
                  dat    <= '0;
                  if (cmd[0]) phase <= PH_PARK;
                  else        addr  <= addr_pg;
               end
            end
            PH_RDAT: begin
               miso_q <= dat[~bitcnt[2:0]];
               bitcnt <= bitcnt + 1'b1;
               if (last8) begin
                  bitcnt <= '0;
                  if (cmd == CMD_READ) begin
                     addr <= addr + 1'b1;
                     dat  <= mem_rdata;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   if (HI_W < 2) begin : g_bad_page
      $error("spi_ee_ctrl: PAGE_W must leave at least two upper address bits");
   end
endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave #(
   parameter int ADDR_W = 10,
   parameter int PAGE_W = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_csn,
   input  logic spi_sck,
   input  logic spi_mosi,
   input  logic spi_holdn,
   output logic spi_miso
);
   logic [3:0]        sync_q;
   logic              cs_s, sck_s, mosi_s, hold_s, sck_q, sck_rise;
   logic              wel, set_wel, clr_wel, ld_prot;
   logic [1:0]        prot, prot_new;
   logic              mem_we;
   logic [ADDR_W-1:0] mem_waddr, mem_raddr;
   logic [7:0]        mem_wdata, mem_rdata;

   if (ADDR_W > 16 || ADDR_W < 4) begin : g_bad_addr
      $error("spi_eeprom_slave: ADDR_W must lie in 4..16");
   end
   if (PAGE_W < 1 || PAGE_W > ADDR_W - 2) begin : g_bad_pw
      $error("spi_eeprom_slave: PAGE_W out of range");
   end

   spi_ee_sync #(.N(4), .RST_VAL(4'b1001)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({spi_holdn, spi_mosi, spi_sck, spi_csn}),
      .q     (sync_q)
   );
   assign {hold_s, mosi_s, sck_s, cs_s} = sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_q <= 1'b0;
      else        sck_q <= sck_s;
   end
   assign sck_rise = sck_s & ~sck_q;

   spi_ee_status u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_wel (set_wel),
      .clr_wel (clr_wel),
      .ld_prot (ld_prot),
      .prot_in (prot_new),
      .wel     (wel),
      .prot    (prot)
   );

   spi_ee_mem #(.ADDR_W(ADDR_W)) u_mem (
      .clk   (clk),
      .we    (mem_we),
      .waddr (mem_waddr),
      .wdata (mem_wdata),
      .raddr (mem_raddr),
      .rdata (mem_rdata)
   );

   spi_ee_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_s      (cs_s),
      .hold_s    (hold_s),
      .mosi_s    (mosi_s),
      .sck_rise  (sck_rise),
      .wel       (wel),
      .prot      (prot),
      .set_wel   (set_wel),
      .clr_wel   (clr_wel),
      .ld_prot   (ld_prot),
      .prot_new  (prot_new),
      .mem_we    (mem_we),
      .mem_waddr (mem_waddr),
      .mem_raddr (mem_raddr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .miso      (spi_miso)
   );
endmodule

// File: rtl/spi_ee_chk.sv
module spi_ee_chk #(
   parameter int AW = 10
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cs_s,
   input logic          hold_s,
   input logic          sck_rise,
   input logic          miso,
   input logic          wel,
   input logic [1:0]    prot,
   input logic          mem_we,
   input logic [AW-1:0] mem_waddr
);
   localparam int DEPTH = 1 << AW;
   logic live;
   assign live = hold_s & ~cs_s & sck_rise;

   assert_miso_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !live |=> $stable(miso));

   assert_hold_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !hold_s |=> $stable(wel) && $stable(prot) && $stable(miso));

   assert_hold_nowrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !hold_s |-> !mem_we);

   assert_wel_on_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !live |=> $stable(wel));

   assert_prot_on_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !live |=> $stable(prot));

   assert_write_needs_wel_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> wel);

   assert_all_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (prot == 2'b11) |-> !mem_we);

   assert_half_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && prot == 2'b10) |-> (int'(mem_waddr) < DEPTH / 2));

   assert_quarter_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && prot == 2'b01) |-> (int'(mem_waddr) < (DEPTH / 4) * 3));
endmodule

bind spi_eeprom_slave spi_ee_chk #(.AW(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_s      (cs_s),
   .hold_s    (hold_s),
   .sck_rise  (sck_rise),
   .miso      (spi_miso),
   .wel       (wel),
   .prot      (prot),
   .mem_we    (mem_we),
   .mem_waddr (mem_waddr)
);

// File: tb/spi_eeprom_slave_tb.sv
module spi_eeprom_slave_tb;
   localparam int AW    = 10;
   localparam int PW    = 7;
   localparam int DEPTH = 1 << AW;
   localparam int PAGE  = 1 << PW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic csn = 1'b1, sck = 1'b0, mosi = 1'b0, holdn = 1'b1;
   logic miso;

   always #5 clk = ~clk;

   spi_eeprom_slave #(.ADDR_W(AW), .PAGE_W(PW)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .spi_csn   (csn),
      .spi_sck   (sck),
      .spi_mosi  (mosi),
      .spi_holdn (holdn),
      .spi_miso  (miso)
   );

   int    vecs = 0, bad = 0;
   bit    done = 0;
   string tag = "R1";
   logic  exp_miso = 1'b0;

   // behavioural model of the protocol
   int         mph = 0, mcnt = 0, madr = 0;
   logic [7:0] mop = 0, mbuf = 0;
   logic [15:0] mash = 0;
   logic       mwel = 0, mout = 0;
   logic [1:0] mbp = 0;
   logic [7:0] mm [DEPTH];

   initial for (int i = 0; i < DEPTH; i++) mm[i] = 8'hxx;

   function automatic bit locked(input int a);
      case (mbp)
         2'b01:   return a >= DEPTH - DEPTH / 4;
         2'b10:   return a >= DEPTH / 2;
         2'b11:   return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   task automatic model_rise(input logic b);
      case (mph)
         0: begin
            mop = {mop[6:0], b}; mcnt++;
            if (mcnt == 8) begin
               mcnt = 0;
               case (mop)
                  8'h01: begin mbuf = 0; mph = 2; end
                  8'h02, 8'h03: begin mash = 0; mph = 1; end
                  8'h04: begin mwel = 0; mph = 4; end
                  8'h05: begin mbuf = {4'b0, mbp, mwel, 1'b0}; mph = 3; end
                  8'h06: begin mwel = 1; mph = 4; end
                  default: mph = 4;
               endcase
            end
         end
         1: begin
            mash = {mash[14:0], b}; mcnt++;
            if (mcnt == 16) begin
               mcnt = 0;
               madr = int'(mash) % DEPTH;
               if (mop[0]) begin mbuf = mm[madr]; mph = 3; end
               else begin mbuf = 0; mph = 2; end
            end
         end
         2: begin
            mbuf = {mbuf[6:0], b}; mcnt++;
            if (mcnt == 8) begin
               mcnt = 0;
               if (mop[0]) begin mbp = mbuf[3:2]; mph = 4; end
               else begin
                  if (mwel && !locked(madr)) mm[madr] = mbuf;
                  mbuf = 0;
                  madr = (madr / PAGE) * PAGE + (madr + 1) % PAGE;
               end
            end
         end
         3: begin
            mout = mbuf[7 - mcnt]; mcnt++;
            if (mcnt == 8) begin
               mcnt = 0;
               if (mop == 8'h03) begin madr = (madr + 1) % DEPTH; mbuf = mm[madr]; end
            end
         end
         default: ;
      endcase
   endtask

   always @(negedge clk) begin
      if (rst_n && !done && exp_miso !== 1'bx) begin
         vecs++;
         if (miso !== exp_miso) begin
            bad++;
            $display("FAIL %s: miso got %b expected %b at %0t", tag, miso, exp_miso, $time);
         end
      end
   end

   task automatic bit_out(input logic b);
      logic live;
      @(negedge clk); mosi = b;
      repeat (3) @(negedge clk);
      sck = 1'b1;
      live = holdn & ~csn;
      if (live) model_rise(b);
      repeat (3) @(posedge clk);
      if (live) exp_miso = mout;
      repeat (3) @(negedge clk);
      sck = 1'b0;
   endtask

   task automatic send(input logic [7:0] v);
      for (int i = 7; i >= 0; i--) bit_out(v[i]);
   endtask

   task automatic send16(input logic [15:0] v);
      send(v[15:8]); send(v[7:0]);
   endtask

   task automatic sel;
      @(negedge clk); csn = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic desel;
      @(negedge clk); csn = 1'b1;
      if (holdn) begin mph = 0; mcnt = 0; mop = 0; end
      repeat (4) @(negedge clk);
   endtask

   task automatic cmd1(input logic [7:0] c);
      sel; send(c); desel;
   endtask

   task automatic wrstat(input logic [7:0] v);
      sel; send(8'h01); send(v); desel;
   endtask

   task automatic rdstat;
      sel; send(8'h05); send(8'h00); send(8'h00); desel;
   endtask

   task automatic wr2(input logic [15:0] a, input logic [7:0] d);
      sel; send(8'h02); send16(a); send(d); desel;
   endtask

   task automatic rdn(input logic [15:0] a, input int n);
      sel; send(8'h03); send16(a);
      for (int i = 0; i < n; i++) send(8'h00);
      desel;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++;
         $display("FAIL watchdog: run hung, got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      tag = "R1"; vecs++;
      if (miso !== 1'b0) begin
         bad++; $display("FAIL R1: reset miso got %b expected 0", miso);
      end
      rdstat;

      tag = "R7"; cmd1(8'h06); rdstat;

      tag = "R11"; sel; send(8'h02); send16(16'h03FE);
      send(8'hA1); send(8'hB2); send(8'hC3); desel;
      tag = "R2"; sel; send(8'h02); send16(16'h0000); send(8'h11); send(8'h22); desel;
      wr2(16'h0300, 8'h31); wr2(16'h0200, 8'h42); wr2(16'h0100, 8'h53); wr2(16'h0010, 8'h5A);

      tag = "R6"; rdn(16'h03FE, 4);
      tag = "R5"; rdn(16'hFF80, 1); rdn(16'hFD00, 2);

      tag = "R3"; sel; send(8'h02); send(8'h00); bit_out(1'b0); bit_out(1'b1); desel;
      rdstat;
      sel; send(8'h02); send16(16'h0010); bit_out(1); bit_out(1); bit_out(1); bit_out(1); desel;
      rdn(16'h0010, 1);

      tag = "R4"; sel; send(8'h03); send(8'h00);
      @(negedge clk); holdn = 1'b0; repeat (4) @(negedge clk);
      send(8'hFF);
      desel; sel;
      @(negedge clk); holdn = 1'b1; repeat (4) @(negedge clk);
      send(8'h01); send(8'h00); send(8'h00); desel;

      tag = "R12"; sel; send(8'hAB); send(8'hFF); send(8'h00); desel;
      rdstat;

      tag = "R8"; wrstat(8'h04); rdstat;
      tag = "R10"; wr2(16'h0300, 8'h77); wr2(16'h02FF, 8'h66);
      rdn(16'h02FF, 2);
      wrstat(8'h08); wr2(16'h0200, 8'h88); wr2(16'h0100, 8'h13);
      rdn(16'h0100, 1); rdn(16'h0200, 1);
      wrstat(8'h0C); rdstat; wr2(16'h0000, 8'h99); rdn(16'h0000, 1);
      wrstat(8'h00);

      tag = "R9"; cmd1(8'h04); rdstat; wr2(16'h0001, 8'hEE); rdn(16'h0000, 2);
      tag = "R7"; cmd1(8'h06); rdstat; cmd1(8'h04); rdstat;

      repeat (4) @(negedge clk);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
   end
endmodule